// File: doc/BRIEF.md
# Switchable-Width Noise Shift Register

This block makes the pseudo-random bit stream for a noise voice. A Fibonacci shift register advances by one step on each cycle in which the tick input is high. The register can run over its full 15 stages or over only its lowest 7 stages. In both widths one rule sets the feedback: the exclusive-OR of the two lowest stages enters at the top of the active width. The lowest stage is the noise sample that goes to a downstream envelope stage.

A trigger pulse loads every stage with 1 and starts the voice. If the timed mode is enabled, a length-expired flag from the length counter stops the voice. If it is disabled, that flag does nothing and the voice plays until the next reset. While the voice is stopped, the sample is held at 0 and the register keeps its contents.

The noise sample is a level that changes only after a tick. The downstream stage reads it whenever it needs a value, so the block has no valid/ready handshake and applies no back-pressure. A tick can never be refused.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While `rst_n` is low, and after it goes high with no trigger yet, `active_o` and `noise_o` are both 0.
- R2: A clock edge with `trig_i` high loads every register stage with 1 and sets `active_o`. From the following cycle, `noise_o` is 1 until the next step.
- R3: With `short_mode_i` = 0 (15-stage width), each step moves every stage down by one toward stage 1, the lowest bit. The top stage (stage 15) takes stage 1 XOR stage 2.
- R4: With `short_mode_i` = 1 (7-stage width), the XOR of stages 1 and 2 enters stage 7 and stages 1 to 6 shift down. Stages 8 to 15 take no part. After a trigger, the first eight samples are 1,1,1,1,1,1,1,0.
- R5: The sample sequence repeats every 127 steps in the 7-stage width and every 32767 steps in the 15-stage width. The register never holds all zeros.
- R6: With `timed_i` = 1, a clock edge that sees `len_done_i` high and no trigger clears `active_o`.
- R7: With `timed_i` = 0, `len_done_i` has no effect: `active_o` stays 1 and the samples go on unchanged.
- R8: While `active_o` is 0, `noise_o` is 0 and ticks do not advance the register.
- R9: A trigger wins over a tick and over length expiry that arrive at the same edge. The result is a loaded, active register, with no step and no stop.
- R10: A step happens only at an edge where `tick_i` is high and the voice is active. Gaps between ticks of any length leave the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Step strobe from the frequency divider |
| short_mode_i | input | 1 | Width select: 0 = 15 stages, 1 = 7 stages |
| trig_i | input | 1 | Restart pulse: reload and activate |
| timed_i | input | 1 | 1 = stop when the length expires |
| len_done_i | input | 1 | Length-expired flag from the length counter |
| noise_o | output | 1 | Gated noise sample (stage 1) |
| active_o | output | 1 | Voice is playing |

## Verification
The assertions assume that the register was loaded by reset or by a trigger. They also assume the width select does not change between triggers, so that the all-ones start leads into a maximal-length cycle. The bench changes `short_mode_i` only in the cycle of a trigger. Every input is driven half a cycle away from the clock edge. The bench checks the stated opening sample patterns, and it checks that the output repeats after exactly 127 or 32767 steps.

// File: rtl/noise_pkg.sv
package noise_pkg;
  typedef enum logic {
    WIDTH_LONG  = 1'b0,
    WIDTH_SHORT = 1'b1
  } width_sel_e;

  localparam int unsigned DEF_LONG_STAGES  = 15;
  localparam int unsigned DEF_SHORT_STAGES = 7;
endpackage

// File: rtl/noise_shift_core.sv
module noise_shift_core #(
  parameter int unsigned LONG_STAGES  = noise_pkg::DEF_LONG_STAGES,
  parameter int unsigned SHORT_STAGES = noise_pkg::DEF_SHORT_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic adv_i,
  input  logic short_i,
  output logic s1_o
);
  localparam int unsigned LTOP = LONG_STAGES - 1;
  localparam int unsigned STOP = SHORT_STAGES - 1;

  logic [LTOP:0] state_q;
  logic [LTOP:0] state_d;
  logic          fb;

  assign fb = state_q[0] ^ state_q[1];

  // Per-stage next value; the width select decides where feedback enters.
  for (genvar i = 0; i < LONG_STAGES; i++) begin : g_stage
    logic nxt_long;
    logic nxt_short;
    if (i == LTOP) begin : g_ltop
      assign nxt_long = fb;
    end else begin : g_lmid
      assign nxt_long = state_q[i+1];
    end
    if (i == STOP) begin : g_stop
      assign nxt_short = fb;
    end else if (i < STOP) begin : g_smid
      assign nxt_short = state_q[i+1];
    end else begin : g_shold
      assign nxt_short = state_q[i];
    end
    assign state_d[i] = short_i ? nxt_short : nxt_long;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load_i) begin
      state_q <= '1;
    end else if (adv_i) begin
      state_q <= state_d;
    end
  end

  assign s1_o = state_q[0];

  // R5: zero state is unreachable from the all-ones start
  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R2: a load leaves every stage at one
  p_load_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (state_q == '1));
  // R8: without a step or load the register keeps its contents
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(state_q));
endmodule

// File: rtl/noise_run_ctrl.sv
module noise_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic timed_i,
  input  logic len_done_i,
  output logic active_o
);
  logic stop_req;

  assign stop_req = timed_i && len_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
    end else if (trig_i) begin
      active_o <= 1'b1;
    end else if (stop_req) begin
      active_o <= 1'b0;
    end
  end

  // R6: an expiry in timed mode stops the voice
  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_i && len_done_i && !trig_i) |=> !active_o);
  // R7: with timed mode off the voice keeps playing
  p_untimed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !timed_i) |=> active_o);
  // R9: a trigger always starts the voice
  p_trig_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> active_o);
endmodule

// File: rtl/noise_out_gate.sv
module noise_out_gate (
  input  logic active_i,
  input  logic s1_i,
  output logic noise_o
);
  always_comb begin
    noise_o = 1'b0;
    if (active_i) begin
      noise_o = s1_i;
    end
  end
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen #(
  parameter int unsigned LONG_STAGES  = noise_pkg::DEF_LONG_STAGES,
  parameter int unsigned SHORT_STAGES = noise_pkg::DEF_SHORT_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic short_mode_i,
  input  logic trig_i,
  input  logic timed_i,
  input  logic len_done_i,
  output logic noise_o,
  output logic active_o
);
  logic adv;
  logic s1;
  noise_pkg::width_sel_e wsel;

  assign wsel = noise_pkg::width_sel_e'(short_mode_i);
  // R10: a step needs a tick while the voice is active; a trigger overrides it
  assign adv  = tick_i && active_o && !trig_i;

  noise_run_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .timed_i    (timed_i),
    .len_done_i (len_done_i),
    .active_o   (active_o)
  );

  noise_shift_core #(
    .LONG_STAGES  (LONG_STAGES),
    .SHORT_STAGES (SHORT_STAGES)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (trig_i),
    .adv_i   (adv),
    .short_i (wsel == noise_pkg::WIDTH_SHORT),
    .s1_o    (s1)
  );

  noise_out_gate u_gate (
    .active_i (active_o),
    .s1_i     (s1),
    .noise_o  (noise_o)
  );

  // R2: the voice starts on a sample of one
  p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> noise_o);
  // R1: the voice is idle in the first cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    (!rst_n) |=> !active_o);
endmodule

// File: tb/noise_lfsr_gen_tb_top.sv
module noise_lfsr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, short_mode_i = 1'b0, trig_i = 1'b0;
  logic timed_i = 1'b0, len_done_i = 1'b0;
  logic noise_o, active_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";

  bit [14:0] m_reg = '1;
  bit        m_act = 1'b0;
  bit        m_short = 1'b0;

  always #10 clk = ~clk;

  noise_lfsr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .short_mode_i(short_mode_i),
    .trig_i(trig_i), .timed_i(timed_i), .len_done_i(len_done_i),
    .noise_o(noise_o), .active_o(active_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural model of one clock edge
  task automatic model_edge(input bit t, input bit tr, input bit tm, input bit ld);
    bit fb;
    if (!rst_n) begin
      m_reg = '1; m_act = 1'b0;
    end else if (tr) begin
      m_reg = '1; m_act = 1'b1;
    end else begin
      if (t && m_act) begin
        fb = m_reg[0] ^ m_reg[1];
        if (m_short) m_reg = {m_reg[14:7], fb, m_reg[6:1]};
        else         m_reg = {fb, m_reg[14:1]};
      end
      if (tm && ld) m_act = 1'b0;
    end
  endtask

  task automatic cyc(input bit t, input bit tr, input bit tm, input bit ld);
    @(negedge clk);
    tick_i = t; trig_i = tr; timed_i = tm; len_done_i = ld;
    @(posedge clk);
    model_edge(t, tr, tm, ld);
    #1;
    check(cur_req, active_o, m_act, "active");
    check(cur_req, noise_o, m_act ? m_reg[0] : 1'b0, "noise");
  endtask

  task automatic trigger(input bit sh);
    @(negedge clk);
    short_mode_i = sh;
    m_short = sh;
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stim
    bit seq[$];
    repeat (3) @(posedge clk);
    #1;
    check("R1", active_o, 0, "active in reset");
    check("R1", noise_o, 0, "noise in reset");
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R8";
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R1", active_o, 0, "idle after reset");

    // Long width, one full period with sparse length flags
    cur_req = "R2";
    trigger(1'b0);
    check("R2", noise_o, 1, "first sample");
    cur_req = "R3";
    seq.delete();
    for (int i = 0; i < 32767 + 16; i++) begin
      cyc(1'b1, 1'b0, 1'b0, (i % 1000) == 7);
      seq.push_back(noise_o);
    end
    check("R7", active_o, 1, "still active untimed");
    for (int i = 0; i < 16; i++)
      check("R5", seq[i + 32767], seq[i], "long period repeat");
    check("R3", seq[32767 - 1], 1, "long sample returns to start");
    check("R3", seq[0], 1, "long second sample");
    check("R3", seq[13], 1, "long 15th sample");
    check("R3", seq[14], 0, "long 16th sample");

    // Short width with irregular tick gaps
    cur_req = "R4";
    trigger(1'b1);
    seq.delete();
    seq.push_back(noise_o);
    for (int i = 0; i < 127 + 8; i++) begin
      cur_req = "R10";
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      if (i % 3 == 0) cyc(1'b0, 1'b0, 1'b0, 1'b0);
      cur_req = "R4";
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      seq.push_back(noise_o);
    end
    for (int i = 0; i < 7; i++) check("R4", seq[i], 1, "short opening ones");
    check("R4", seq[7], 0, "short eighth sample");
    for (int i = 0; i < 8; i++)
      check("R5", seq[i + 127], seq[i], "short period repeat");

    // Timed stop
    cur_req = "R6";
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0);
    check("R6", active_o, 1, "timed before expiry");
    cyc(1'b1, 1'b0, 1'b1, 1'b1);
    check("R6", active_o, 0, "stopped on expiry");
    cur_req = "R8";
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      check("R8", noise_o, 0, "quiet while idle");
    end

    // Trigger with tick and expiry in the same edge
    cur_req = "R9";
    @(negedge clk); short_mode_i = 1'b0; m_short = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, 1'b1);
    check("R9", active_o, 1, "trigger wins");
    check("R9", noise_o, 1, "loaded not stepped");
    cur_req = "R3";
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule